// File: doc/BRIEF.md
# IDE Multiword DMA Handshake Engine

This block runs the device-facing side of an IDE DMA transfer for one port while a bus master owns the data path. When the master enable is set and the drive raises its DMA request, the engine lowers the acknowledge line. It then produces read or write strobes with programmable active and inactive widths, counted in clocks. After every completed strobe it sends a one-clock word pulse toward the data buffer.

Nothing selects single-word or multiword mode. The engine keeps running while the request is still high when a strobe ends. Once the request drops, the strobe in progress is the last one, and the acknowledge releases one clock after that strobe ends. Strobes also pause while the host buffer is not ready. Clearing the master enable stops the burst cleanly. While the master enable is set, the port's chip selects are held inactive.

Top module: `ide_mwdma_engine`

## Requirements
- R1: While `bm_en` is 1, `cs_n` is all ones; while `bm_en` is 0, `cs_n` equals `pio_cs_n`.
- R2: With the engine idle, `bm_en`=1 and `dev_req`=1 at a rising edge, `dack_n` is 0 after that edge. With `bm_en`=0, `dev_req` has no effect and `dack_n` stays 1.
- R3: A strobe asserts one clock after `dack_n` falls (host ready). `dir_rd`=1 selects `rd_stb_n`, and `dir_rd`=0 selects `wr_stb_n`. The two strobes are never low together.
- R4: Each strobe is low for max(`t_on`,1) clocks. Between strobes of a burst, the strobe is high for max(`t_off`,1) clocks.
- R5: If `dev_req` is still 1 in the last clock of a strobe, another strobe follows.
- R6: If `dev_req` is 0 at any clock after the acknowledge and before the strobe ends, that strobe is the last one. `dack_n` rises one clock after the strobe rises, and no further strobe occurs while `dev_req` stays 0.
- R7: `word_pulse` is 1 for exactly the first clock after each strobe ends. On reads, `word_data` then holds the `rd_data` value present in the strobe's last clock.
- R8: If `host_rdy` is 0 where a strobe would start, the strobe stays high and `dack_n` stays low. The strobe asserts one clock after `host_rdy` returns to 1.
- R9: If `bm_en` is cleared during a strobe, that strobe completes at full width. `dack_n` then rises one clock later and no further strobe follows.
- R10: After reset, `dack_n`, `rd_stb_n` and `wr_stb_n` are 1 and `word_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bm_en | input | 1 | Bus-master enable |
| dir_rd | input | 1 | 1 = device-to-host (read), 0 = host-to-device (write) |
| dev_req | input | 1 | Device DMA request, active high |
| host_rdy | input | 1 | Host buffer can accept or supply a word |
| t_on | input | CNT_W | Strobe active width in clocks (0 treated as 1) |
| t_off | input | CNT_W | Strobe inactive width in clocks (0 treated as 1) |
| pio_cs_n | input | CS_W | Chip selects from the programmed-I/O path |
| rd_data | input | DATA_W | Device data bus |
| cs_n | output | CS_W | Gated chip selects to the drive |
| dack_n | output | 1 | DMA acknowledge, active low |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| word_pulse | output | 1 | One-clock pulse per completed word |
| word_data | output | DATA_W | Word captured at the end of a read strobe |

## Verification
The bench builds the engine with `CNT_W`=3 and `DATA_W`=8. This makes a full sweep possible: every pair of on and off widths from 0 to 7, in both directions, including the zero-width cases that must behave as one clock. Each sweep point runs a two-word burst with the request dropped during the second strobe. This covers continuation, last-cycle release and word capture at every timing. Directed runs then cover a request dropped before the first strobe, a host-not-ready pause, enable withdrawn mid-strobe, chip-select gating and a request ignored while disabled.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_ON,
        ST_OFF,
        ST_HOLD,
        ST_REL
    } dma_st_e;
endpackage

// File: rtl/ide_dma_timer.sv
module ide_dma_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (load_val == ZERO) ? ZERO : load_val - 1'b1;
        end else if (cnt_q != ZERO) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == ZERO);

    // R4
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == ZERO) |=> (cnt_q == ZERO));
endmodule

// File: rtl/ide_dma_fsm.sv
module ide_dma_fsm
    import ide_dma_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bm_en,
    input  logic              dir_rd,
    input  logic              dev_req,
    input  logic              host_rdy,
    input  logic [CNT_W-1:0]  t_on,
    input  logic [CNT_W-1:0]  t_off,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              dack_n,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic              word_pulse,
    output logic [DATA_W-1:0] word_data
);
    typedef struct packed {
        dma_st_e           st;
        logic              rd;
        logic              dropped;
        logic              pulse;
        logic [DATA_W-1:0] data;
    } fsm_regs_t;

    fsm_regs_t d, q;

    always_comb begin
        d        = q;
        d.pulse  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = t_on;
        unique case (q.st)
            ST_IDLE: begin
                if (bm_en && dev_req) begin
                    d.st      = ST_ACK;
                    d.rd      = dir_rd;
                    d.dropped = 1'b0;
                end
            end
            ST_ACK, ST_HOLD: begin
                if (!dev_req) d.dropped = 1'b1;
                if (!bm_en) begin
                    d.st = ST_REL;
                end else if (host_rdy) begin
                    d.st     = ST_ON;
                    tmr_load = 1'b1;
                    tmr_val  = t_on;
                end
            end
            ST_ON: begin
                if (tmr_done) begin
                    d.pulse = 1'b1;
                    if (q.rd) d.data = rd_data;
                    if (bm_en && dev_req && !q.dropped) begin
                        d.st      = ST_OFF;
                        d.dropped = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = t_off;
                    end else begin
                        d.st = ST_REL;
                    end
                end else if (!dev_req) begin
                    d.dropped = 1'b1;
                end
            end
            ST_OFF: begin
                if (!dev_req) d.dropped = 1'b1;
                if (!bm_en) begin
                    d.st = ST_REL;
                end else if (tmr_done) begin
                    if (host_rdy) begin
                        d.st     = ST_ON;
                        tmr_load = 1'b1;
                        tmr_val  = t_on;
                    end else begin
                        d.st = ST_HOLD;
                    end
                end
            end
            ST_REL:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.rd      <= 1'b0;
            q.dropped <= 1'b0;
            q.pulse   <= 1'b0;
            q.data    <= '0;
        end else begin
            q <= d;
        end
    end

    assign dack_n     = (q.st == ST_IDLE);
    assign rd_stb_n   = !((q.st == ST_ON) && q.rd);
    assign wr_stb_n   = !((q.st == ST_ON) && !q.rd);
    assign word_pulse = q.pulse;
    assign word_data  = q.data;

    // R2
    ack_next_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && bm_en && dev_req) |=> !dack_n);

    // R3
    stb_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_n || !wr_stb_n) |-> (!dack_n && $past(!dack_n)));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rd_stb_n, !wr_stb_n}));

    // R7
    pulse_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_pulse |-> (rd_stb_n && wr_stb_n && $past(!rd_stb_n || !wr_stb_n)));

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack_n) |-> $past(rd_stb_n && wr_stb_n));
endmodule

// File: rtl/ide_mwdma_engine.sv
module ide_mwdma_engine #(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 16,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bm_en,
    input  logic              dir_rd,
    input  logic              dev_req,
    input  logic              host_rdy,
    input  logic [CNT_W-1:0]  t_on,
    input  logic [CNT_W-1:0]  t_off,
    input  logic [CS_W-1:0]   pio_cs_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic [CS_W-1:0]   cs_n,
    output logic              dack_n,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic              word_pulse,
    output logic [DATA_W-1:0] word_data
);
    localparam logic [CS_W-1:0] CS_IDLE = '1;

    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    assign cs_n = bm_en ? CS_IDLE : pio_cs_n;

    ide_dma_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    ide_dma_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bm_en      (bm_en),
        .dir_rd     (dir_rd),
        .dev_req    (dev_req),
        .host_rdy   (host_rdy),
        .t_on       (t_on),
        .t_off      (t_off),
        .rd_data    (rd_data),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .dack_n     (dack_n),
        .rd_stb_n   (rd_stb_n),
        .wr_stb_n   (wr_stb_n),
        .word_pulse (word_pulse),
        .word_data  (word_data)
    );
endmodule

// File: tb/ide_mwdma_engine_tb.sv
module ide_mwdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bm_en = 1'b0, dir_rd = 1'b0, dev_req = 1'b0, host_rdy = 1'b1;
    logic [CW-1:0] t_on = '0, t_off = '0;
    logic [1:0]    pio_cs_n = 2'b00;
    logic [DW-1:0] rd_data = '0;
    logic [1:0]    cs_n;
    logic          dack_n, rd_stb_n, wr_stb_n, word_pulse;
    logic [DW-1:0] word_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_mwdma_engine #(.CNT_W(CW), .DATA_W(DW), .CS_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .dir_rd(dir_rd),
        .dev_req(dev_req), .host_rdy(host_rdy), .t_on(t_on), .t_off(t_off),
        .pio_cs_n(pio_cs_n), .rd_data(rd_data), .cs_n(cs_n), .dack_n(dack_n),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .word_pulse(word_pulse),
        .word_data(word_data)
    );

    wire any_stb = !rd_stb_n || !wr_stb_n;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic go_idle();
        dev_req = 1'b0;
        bm_en   = 1'b0;
        host_rdy = 1'b1;
        repeat (4) tick();
    endtask

    task automatic sweep_point(input int on, input int off, input bit rd);
        int eon  = (on == 0) ? 1 : on;
        int eoff = (off == 0) ? 1 : off;
        int n;
        bit right;
        t_on = CW'(on); t_off = CW'(off); dir_rd = rd;
        rd_data = DW'((on * 8 + off) ^ (rd ? 8'hA5 : 8'h00));
        bm_en = 1'b1; host_rdy = 1'b1; dev_req = 1'b1;
        tick();
        chk(!dack_n && !any_stb, "R2 ack one clock after request", int'(dack_n), 0);
        tick();
        right = rd ? (!rd_stb_n && wr_stb_n) : (!wr_stb_n && rd_stb_n);
        chk(right, "R3 strobe of selected direction", int'({rd_stb_n, wr_stb_n}), rd ? 1 : 2);
        n = 0;
        while (any_stb && n < 20) begin n++; tick(); end
        chk(n == eon, "R4 first strobe width", n, eon);
        chk(word_pulse == 1'b1, "R7 word pulse after strobe", int'(word_pulse), 1);
        if (rd) chk(word_data == rd_data, "R7 captured read word", int'(word_data), int'(rd_data));
        n = 0;
        while (!any_stb && n < 20) begin
            if (n == 1) chk(word_pulse == 1'b0, "R7 pulse lasts one clock", int'(word_pulse), 0);
            n++; tick();
        end
        chk(n == eoff, "R4 gap width between strobes", n, eoff);
        chk(any_stb, "R5 second strobe with request held", int'(any_stb), 1);
        dev_req = 1'b0;
        n = 0;
        while (any_stb && n < 20) begin n++; tick(); end
        chk(n == eon, "R4 second strobe width", n, eon);
        chk(!dack_n && word_pulse, "R6 ack held in clock after last strobe", int'(dack_n), 0);
        tick();
        chk(dack_n == 1'b1, "R6 ack released one clock after strobe", int'(dack_n), 1);
        repeat (3) tick();
        chk(dack_n && !any_stb, "R6 no strobe after last cycle", int'(any_stb), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        // R10 reset state
        chk(dack_n && rd_stb_n && wr_stb_n && !word_pulse, "R10 reset outputs",
            int'({dack_n, rd_stb_n, wr_stb_n, word_pulse}), 14);
        rst_n = 1'b1;
        tick();
        chk(cs_n == pio_cs_n, "R1 chip selects pass when disabled", int'(cs_n), int'(pio_cs_n));

        // R2 request ignored while master disabled
        dev_req = 1'b1;
        repeat (4) tick();
        chk(dack_n && !any_stb, "R2 request ignored with enable low", int'(dack_n), 1);
        dev_req = 1'b0;

        // R1 chip select gating
        bm_en = 1'b1; pio_cs_n = 2'b01;
        tick();
        chk(cs_n == 2'b11, "R1 chip selects held high", int'(cs_n), 3);
        go_idle();

        for (int rd = 0; rd < 2; rd++)
            for (int on = 0; on < 8; on++)
                for (int off = 0; off < 8; off++) begin
                    sweep_point(on, off, rd[0]);
                    go_idle();
                end

        // R6 request dropped before first strobe: single word
        t_on = 3'd2; t_off = 3'd2; dir_rd = 1'b0;
        bm_en = 1'b1; dev_req = 1'b1;
        tick();
        dev_req = 1'b0;
        tick();
        chk(!wr_stb_n, "R6 single word strobe starts", int'(wr_stb_n), 0);
        n = 0;
        while (any_stb && n < 20) begin n++; tick(); end
        chk(n == 2 && !dack_n, "R6 single word width and ack held", n, 2);
        tick();
        chk(dack_n == 1'b1, "R6 single word ack release", int'(dack_n), 1);
        go_idle();

        // R8 host not ready holds strobe, keeps ack
        t_on = 3'd1; dir_rd = 1'b1;
        bm_en = 1'b1; host_rdy = 1'b0; dev_req = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!dack_n && !any_stb, "R8 strobe held while host not ready", int'(any_stb), 0);
        end
        host_rdy = 1'b1;
        tick();
        chk(!rd_stb_n && !dack_n, "R8 strobe one clock after ready", int'(rd_stb_n), 0);
        dev_req = 1'b0;
        go_idle();

        // R9 enable withdrawn mid-strobe
        t_on = 3'd3; t_off = 3'd1; dir_rd = 1'b0; pio_cs_n = 2'b10;
        bm_en = 1'b1; dev_req = 1'b1;
        tick(); tick();
        chk(!wr_stb_n, "R9 strobe running", int'(wr_stb_n), 0);
        bm_en = 1'b0;
        n = 1; tick();
        chk(cs_n == 2'b10, "R1 chip selects follow PIO after disable", int'(cs_n), 2);
        while (any_stb && n < 20) begin n++; tick(); end
        chk(n == 3 && !dack_n, "R9 strobe completes at full width", n, 3);
        tick();
        chk(dack_n == 1'b1, "R9 ack released", int'(dack_n), 1);
        repeat (3) tick();
        chk(dack_n && !any_stb, "R9 no further strobe", int'(any_stb), 0);
        go_idle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule